// File: doc/BRIEF.md
# Bisection Frequency-Lock Controller

This block brings a digitally controlled oscillator to the frequency that a selected multiplication ratio asks for. It runs in the reference-clock domain. The oscillator output, after a fixed prescaler, comes back as a feedback clock. Each measurement counts that clock's rising edges over a fixed window of reference cycles and compares the count with a target. The target is derived from the ratio.

The control word is found by successive approximation. The search starts at mid-scale. Each comparison settles one bit, most significant first. A bit is kept when the oscillator is too slow and cleared when it is too fast. An exact match ends the search early. Lock time is therefore bounded by the word width. When the search ends, the lock flag rises and the word holds until the next start pulse or reset.

The integrator picks `WIN_LEN` (window length in reference cycles) and `WIN_SCALE` (expected edges per unit of ratio). `WIN_LEN / WIN_SCALE` must equal the feedback prescale factor. The feedback clock must stay below half the reference frequency.

Top module: `freq_lock_ctrl`

## Requirements
- R1: While reset is high, the word becomes mid-scale (512 for 10 bits), and busy and lock go low. Both counters are cleared.
- R2: A start pulse sets the word to mid-scale, raises busy and drops lock on the following cycle. A start pulse during a search abandons that search and begins a new one.
- R3: A measurement counts feedback rising edges, after a two-flop synchronizer and edge detector, over `WIN_LEN` reference cycles. A count below `ratio*WIN_SCALE` means too slow and keeps the bit under test. A count above it means too fast and clears that bit.
- R4: Bits are decided one per measurement, from MSB to LSB. While a bit is under test, the next lower bit is set as the new trial. A full search raises lock exactly `10*(WIN_LEN+2)+1` cycles after the start edge, one cycle after the LSB decision.
- R5: A count equal to the target ends the search at once, with the current trial word. After k measurements, lock rises exactly `k*(WIN_LEN+2)+1` cycles after the start edge.
- R6: A ratio below 16 is treated as 16, and a ratio above 48 is treated as 48.
- R7: The ratio is captured on the start pulse. Changes to it during a search do not affect the result.
- R8: After lock, the word and the lock flag hold until start or reset, whatever the feedback does. Lock and busy are never high together.
- R9: With an oscillator whose frequency is linear in the word, the final word lies within 32 codes of the ideal word, for ratios 16, 32 and 48.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a search |
| fb_clk | input | 1 | Prescaled oscillator clock, asynchronous |
| ratio | input | RATIO_W | Requested multiplication ratio |
| cw | output | CW_W | Oscillator control word |
| busy | output | 1 | Search in progress |
| lock | output | 1 | Search finished, word settled |

## Verification
A feedback line stuck low forces "too slow" on every step. The word must end at all ones after exactly ten measurements, which checks bit order and full-search timing. A fast fixed feedback forces "too fast" everywhere and must give zero. A feedback period chosen to hit the target exactly must stop after one measurement at mid-scale. A linear oscillator model exercises real convergence at ratio 16, at ratio 48, at out-of-range ratios, with a ratio changed mid-search and with a restart, and separates clamping and capture faults from plain search faults.

// File: rtl/flk_pkg.sv
package flk_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_RUN, SEQ_FIN} seq_state_t;
  typedef enum logic [1:0] {CMP_SLOW, CMP_FAST, CMP_EQUAL} cmp_res_t;
endpackage

// File: rtl/flk_edge_sync.sv
module flk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_in};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/flk_freq_cmp.sv
module flk_freq_cmp
  import flk_pkg::*;
#(
  parameter int WIN_LEN = 256,
  parameter int CNT_W   = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             abort,
  input  logic             edge_hit,
  input  logic [CNT_W-1:0] expected,
  output logic             done,
  output cmp_res_t         result
);
  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

  logic             running;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  assign cnt_nx = cnt_q + CNT_W'(edge_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      win_q   <= '0;
      cnt_q   <= '0;
      done    <= 1'b0;
      result  <= CMP_EQUAL;
    end else begin
      done <= 1'b0;
      if (abort) begin
        running <= 1'b0;
      end else if (go) begin
        running <= 1'b1;
        win_q   <= '0;
        cnt_q   <= '0;
      end else if (running) begin
        cnt_q <= cnt_nx;
        if (win_q == WIN_LAST) begin
          running <= 1'b0;
          done    <= 1'b1;
          if (cnt_nx < expected)      result <= CMP_SLOW;
          else if (cnt_nx > expected) result <= CMP_FAST;
          else                        result <= CMP_EQUAL;
        end else begin
          win_q <= win_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flk_mode_seq.sv
module flk_mode_seq
  import flk_pkg::*;
#(
  parameter int CW_W  = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             done,
  input  cmp_res_t         result,
  output logic             cmp_go,
  output logic             decide,
  output logic [IDX_W-1:0] bit_idx,
  output logic             busy,
  output logic             lock
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(CW_W - 1);

  seq_state_t state_q;

  assign decide = done && (state_q == SEQ_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cmp_go  <= 1'b0;
      bit_idx <= IDX_TOP;
      busy    <= 1'b0;
      lock    <= 1'b0;
    end else begin
      cmp_go <= 1'b0;
      if (start) begin
        state_q <= SEQ_RUN;
        cmp_go  <= 1'b1;
        bit_idx <= IDX_TOP;
        busy    <= 1'b1;
        lock    <= 1'b0;
      end else begin
        case (state_q)
          SEQ_RUN: begin
            if (decide) begin
              if (result == CMP_EQUAL || bit_idx == '0) begin
                state_q <= SEQ_FIN;
              end else begin
                bit_idx <= bit_idx - 1'b1;
                cmp_go  <= 1'b1;
              end
            end
          end
          SEQ_FIN: begin
            busy    <= 1'b0;
            lock    <= 1'b1;
            state_q <= SEQ_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flk_ctrl_word.sv
module flk_ctrl_word
  import flk_pkg::*;
#(
  parameter int CW_W  = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             decide,
  input  cmp_res_t         result,
  input  logic [IDX_W-1:0] bit_idx,
  output logic [CW_W-1:0]  cw
);
  localparam logic [CW_W-1:0] MID = CW_W'(1) << (CW_W - 1);

  logic [CW_W-1:0] nxt;

  always_comb begin
    nxt = cw;
    for (int i = 0; i < CW_W; i++) begin
      if (int'(bit_idx) == i && result == CMP_FAST)      nxt[i] = 1'b0;
      if (int'(bit_idx) == i + 1 && result != CMP_EQUAL) nxt[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) cw <= MID;
    else if (decide)  cw <= nxt;
  end
endmodule

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl
  import flk_pkg::*;
#(
  parameter int CW_W        = 10,
  parameter int RATIO_W     = 6,
  parameter int RATIO_MIN   = 16,
  parameter int RATIO_MAX   = 48,
  parameter int WIN_LEN     = 256,
  parameter int WIN_SCALE   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               fb_clk,
  input  logic [RATIO_W-1:0] ratio,
  output logic [CW_W-1:0]    cw,
  output logic               busy,
  output logic               lock
);
  localparam int IDX_W   = $clog2(CW_W + 1);
  localparam int EXP_MAX = RATIO_MAX * WIN_SCALE;
  localparam int CNT_W   = $clog2(((EXP_MAX > WIN_LEN) ? EXP_MAX : WIN_LEN) + 1);

  logic               edge_hit, cmp_go, cmp_done, decide;
  cmp_res_t           cmp_res;
  logic [IDX_W-1:0]   bit_idx;
  logic [RATIO_W-1:0] ratio_cl;
  logic [CNT_W-1:0]   exp_q;

  always_comb begin
    if (ratio < RATIO_W'(RATIO_MIN))      ratio_cl = RATIO_W'(RATIO_MIN);
    else if (ratio > RATIO_W'(RATIO_MAX)) ratio_cl = RATIO_W'(RATIO_MAX);
    else                                  ratio_cl = ratio;
  end

  always_ff @(posedge clk) begin
    if (rst)        exp_q <= '0;
    else if (start) exp_q <= CNT_W'(int'(ratio_cl) * WIN_SCALE);
  end

  flk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(fb_clk), .rise(edge_hit)
  );

  flk_freq_cmp #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .go(cmp_go), .abort(start), .edge_hit(edge_hit),
    .expected(exp_q), .done(cmp_done), .result(cmp_res)
  );

  flk_mode_seq #(.CW_W(CW_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .done(cmp_done), .result(cmp_res),
    .cmp_go(cmp_go), .decide(decide), .bit_idx(bit_idx), .busy(busy), .lock(lock)
  );

  flk_ctrl_word #(.CW_W(CW_W), .IDX_W(IDX_W)) u_word (
    .clk(clk), .rst(rst), .start(start), .decide(decide), .result(cmp_res),
    .bit_idx(bit_idx), .cw(cw)
  );
endmodule

// File: rtl/freq_lock_ctrl_chk.sv
module freq_lock_ctrl_chk #(
  parameter int CW_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            lock,
  input logic [CW_W-1:0] cw
);
  localparam logic [CW_W-1:0] MID = CW_W'(1) << (CW_W - 1);

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cw == MID) && !busy && !lock);

  // R2
  a_r2_start_mid: assert property (@(posedge clk) disable iff (rst)
    start |=> (cw == MID) && busy && !lock);

  // R4: at most the tested bit and the next trial bit change per cycle
  a_r4_two_bits_max: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !start) |=> ($countones(cw ^ $past(cw)) <= 2));

  // R8
  a_r8_excl: assert property (@(posedge clk) disable iff (rst)
    !(lock && busy));

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (lock && !start) |=> $stable(cw) && lock);
endmodule

bind freq_lock_ctrl freq_lock_ctrl_chk #(.CW_W(CW_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .lock(lock), .cw(cw)
);

// File: tb/freq_lock_ctrl_bench.sv
`timescale 1ns/1ps
module freq_lock_ctrl_bench;
  localparam int W    = 256;
  localparam int STEP = W + 2;

  logic       clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [5:0] ratio = 6'd32;
  logic [9:0] cw;
  logic       busy, lock;
  logic       fb_lin = 1'b0, fb_fix = 1'b0, fb_fast = 1'b0;
  int         fb_mode = 0; // 0 linear, 1 exact target (ratio 20), 2 fast, 3 stuck low
  logic       fb_clk;
  int         checks = 0, failures = 0;

  always #10 clk = ~clk;

  assign fb_clk = (fb_mode == 0) ? fb_lin : (fb_mode == 1) ? fb_fix :
                  (fb_mode == 2) ? fb_fast : 1'b0;

  // oscillator model: f(MHz) = 600 + 2*cw, prescaled by 128
  initial forever begin
    #(64000.0 / (600.0 + 2.0 * real'(cw)));
    fb_lin = ~fb_lin;
  end
  initial begin #3.0; forever begin #64.0; fb_fix = ~fb_fix; end end
  initial begin #1.0; forever begin #30.0; fb_fast = ~fb_fast; end end

  freq_lock_ctrl u_freq_lock_ctrl (
    .clk(clk), .rst(rst), .start(start), .fb_clk(fb_clk),
    .ratio(ratio), .cw(cw), .busy(busy), .lock(lock)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit timing_ok(input int n, input int k);
    return (n - 1) == k * STEP;
  endfunction

  function automatic int ideal_cw(input int r);
    return 25 * r - 300;
  endfunction

  task automatic run_search(input int r, output int n);
    @(negedge clk); ratio = 6'(r); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !lock && cw == 10'd512, "R2", "start state", {busy, lock}, 2);
    n = 0;
    while (!lock && n < 3000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(cw == 10'd512, "R1", "reset word", int'(cw), 512);
    chk(!busy, "R1", "reset busy", int'(busy), 0);
    chk(!lock, "R1", "reset lock", int'(lock), 0);
    rst = 1'b0;
  endtask

  task automatic t_slow();
    int n;
    fb_mode = 3; repeat (10) @(negedge clk);
    run_search(16, n);
    chk(cw == 10'h3FF, "R3", "always slow word", int'(cw), 1023);
    chk(timing_ok(n, 10), "R4", "full search cycles", n, 10 * STEP + 1);
  endtask

  task automatic t_fast();
    int n;
    fb_mode = 2; repeat (10) @(negedge clk);
    run_search(16, n);
    chk(cw == 10'd0, "R3", "always fast word", int'(cw), 0);
    chk(timing_ok(n, 10), "R4", "full search cycles", n, 10 * STEP + 1);
  endtask

  task automatic t_equal();
    int n;
    fb_mode = 1; repeat (20) @(negedge clk);
    run_search(20, n);
    chk(timing_ok(n, 1), "R5", "early stop cycles", n, STEP + 1);
    chk(cw == 10'd512, "R5", "early stop word", int'(cw), 512);
  endtask

  task automatic t_linear(input int r, input int req_r, input string req);
    int n, d, k;
    fb_mode = 0; repeat (10) @(negedge clk);
    run_search(r, n);
    d = int'(cw) - ideal_cw(req_r);
    chk(d <= 32 && d >= -32, req, "converged word", int'(cw), ideal_cw(req_r));
    k = (n - 1) / STEP;
    chk(k >= 1 && k <= 10 && timing_ok(n, k), "R5", "lock on a step boundary",
        n, k * STEP + 1);
  endtask

  task automatic t_latch();
    int n, d;
    fb_mode = 0; repeat (10) @(negedge clk);
    fork
      run_search(32, n);
      begin repeat (5) @(negedge clk); ratio = 6'd16; end
    join
    d = int'(cw) - ideal_cw(32);
    chk(d <= 32 && d >= -32, "R7", "ratio captured at start", int'(cw), ideal_cw(32));
  endtask

  task automatic t_hold();
    logic [9:0] kept;
    kept = cw;
    fb_mode = 2;
    repeat (600) @(negedge clk);
    chk(cw == kept, "R8", "word held after lock", int'(cw), int'(kept));
    chk(lock && !busy, "R8", "lock held", {lock, busy}, 2);
  endtask

  task automatic t_restart();
    int n, d;
    fb_mode = 0;
    @(negedge clk); ratio = 6'd16; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    chk(busy && !lock, "R2", "busy mid search", {busy, lock}, 2);
    run_search(48, n);
    d = int'(cw) - ideal_cw(48);
    chk(d <= 32 && d >= -32, "R2", "restart result", int'(cw), ideal_cw(48));
    chk(n >= STEP + 1 && (n - 1) % STEP == 0, "R2", "restart timing", n, STEP + 1);
  endtask

  initial begin
    #(150000 * 20);
    checks++; failures++;
    $display("FAIL watchdog R1..run actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_slow();
    t_fast();
    t_equal();
    t_linear(16, 16, "R9");
    t_hold();
    t_linear(48, 48, "R9");
    t_linear(32, 32, "R9");
    t_linear(5, 16, "R6");
    t_linear(60, 48, "R6");
    t_latch();
    t_restart();
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule